// File: doc/BRIEF.md
# Passive Serial Configuration Master

This block loads a bitstream into a downstream programmable device through its passive serial configuration pins. A single-cycle start pulse, sampled together with the total byte count, begins a load. The block first pulls the active-low configuration request pin low for a timed interval and checks that the device answers by pulling its active-low status line low. It then releases the request and waits a fixed settling interval. After that it polls until the device releases the status line, giving up after a timeout.

Once the device is ready, the block takes bitstream bytes from a valid/ready stream. It shifts each byte out on the serial data pin, least significant bit first, using a divided serial clock. During this phase it watches for a device checksum error. When every byte has been sent, it requires the device's done input to be high. It then sends a fixed number of extra serial clock pulses and reports success. Any failure ends the load with a 2-bit error code, and the pins return to their idle levels.

All intervals are set by parameters in microseconds and converted to system clock cycles from the clock frequency. The serial clock stays high for `DCLK_DIV` system cycles and low for at least `DCLK_DIV` system cycles, so a slow device can be served by raising the divider.

Top module: `pscfg_master`

## Requirements
- R1: At idle the pins rest at request high, serial clock low and serial data low. An accepted start holds the request pin low for at least PULSE_US × CLK_MHZ system cycles.
- R2: If the synchronized status line is not low when the request pulse ends, the load aborts with error code 0 (`err_code_o` = 2'd0) and no serial clock pulse is sent.
- R3: If the status line has not gone high within TIMEOUT_US × CLK_MHZ cycles of polling after the release wait, the load aborts with error code 1 (2'd1). That error is never raised sooner than this many cycles after the request pin rises.
- R4: Each accepted byte is sent as 8 bits, bit 0 first, with one serial clock rising edge per bit.
- R5: Serial data changes only while the serial clock is low, and never in the same cycle in which the clock falls. Each high phase and each low phase between two bits lasts at least DCLK_DIV system cycles.
- R6: If the synchronized done input is low once all bytes are sent, the load aborts with error code 3 (2'd3) and no extra clock pulses are sent.
- R7: With done high, exactly TRAIL_CLKS (default 12) extra serial clock pulses follow the last data bit. After them `ok_o` is set and the block goes idle.
- R8: If, while bytes are being loaded, the status line is low and the done input is also low, the load aborts with error code 2 (2'd2).
- R9: `err_o` and `err_code_o` keep their values until the next accepted start. An accepted start clears `err_o` and `ok_o` and raises `busy_o`.
- R10: A start pulse that arrives while `busy_o` is high has no effect. The running load keeps its byte count and does not repeat the request pulse.
- R11: On any abort, `busy_o` drops, and the request, serial clock and serial data pins return to their idle levels in the same cycle that `err_o` rises.
- R12: `in_ready_o` is high only in the data phase, when the serializer is free and bytes remain. Exactly the requested number of bytes is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, taken only when idle |
| nbytes_i | input | BYTES_W | Number of bitstream bytes, sampled with the start pulse |
| in_valid_i | input | 1 | Byte stream valid |
| in_data_i | input | 8 | Byte stream data |
| in_ready_o | output | 1 | Byte stream ready |
| nconfig_o | output | 1 | Active-low configuration request pin |
| dclk_o | output | 1 | Serial configuration clock |
| data0_o | output | 1 | Serial configuration data |
| nstatus_i | input | 1 | Active-low device status pin (asynchronous) |
| conf_done_i | input | 1 | Device configuration done pin (asynchronous) |
| busy_o | output | 1 | A load is in progress |
| ok_o | output | 1 | Last load succeeded |
| err_o | output | 1 | Last load aborted |
| err_code_o | output | 2 | Abort reason: 0 no status, 1 timeout, 2 checksum, 3 not done |

## Verification
A device model in the bench answers the request pin in five ways: a normal device, a status line that never goes low, a status line stuck low, a checksum failure after ten bits, and a done pin that never rises. Each case drives a different abort path and checks its own error code. The byte patterns 0xA5, 0x3C, 0x80 and 0x01 are chosen so that a bit-order reversal, a dropped bit or a shifted bit each gives a different serial stream. A scoreboard compares that stream bit by bit. Once the stream is exhausted, the rising edges it sees are counted as trailing clocks. A normal load that also offers one extra byte and receives a second start pulse midway tells apart a correct byte count, a restarted load and an over-accepting stream.

// File: rtl/pscfg_pkg.sv
package pscfg_pkg;

  typedef enum logic [2:0] {
    S_IDLE, S_PULSE, S_RELWAIT, S_POLL, S_LOAD, S_CHECK, S_TRAIL
  } state_e;

  typedef enum logic [1:0] {
    ERR_NOSTATUS = 2'd0,
    ERR_TIMEOUT  = 2'd1,
    ERR_CRC      = 2'd2,
    ERR_NODONE   = 2'd3
  } err_e;

  // microseconds to system clock cycles
  function automatic int unsigned us_to_cyc(input int unsigned mhz, input int unsigned us);
    return mhz * us;
  endfunction

  function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/pscfg_sync.sv
module pscfg_sync #(
  parameter int unsigned W = 2,
  parameter logic [W-1:0] RST = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  for (genvar g = 0; g < W; g++) begin : g_bit
    logic meta_q, hold_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= RST[g];
        hold_q <= RST[g];
      end else begin
        meta_q <= d_i[g];
        hold_q <= meta_q;
      end
    end
    assign q_o[g] = hold_q;
  end

endmodule

// File: rtl/pscfg_timer.sv
module pscfg_timer #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         zero_o
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load_i)         cnt_q <= val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

  // R3: intervals shrink by one per cycle, so a timeout cannot come early
  a_r3_count_down: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/pscfg_shifter.sv
module pscfg_shifter #(
  parameter int unsigned DIV  = 3,
  parameter int unsigned NB_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clear_i,
  input  logic            load_i,
  input  logic [7:0]      pat_i,
  input  logic [NB_W-1:0] nbits_i,
  input  logic            use_data_i,
  output logic            dclk_o,
  output logic            data0_o,
  output logic            busy_o,
  output logic            done_o
);

  localparam int unsigned PH_W = $clog2(2 * DIV);
  localparam logic [PH_W-1:0] PH_RISE = PH_W'(DIV - 1);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(2 * DIV - 1);

  logic            active_q, keep_q, dclk_q, data_q;
  logic [PH_W-1:0] ph_q;
  logic [NB_W-1:0] left_q;
  logic [7:0]      sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0; keep_q <= 1'b0; dclk_q <= 1'b0; data_q <= 1'b0;
      ph_q <= '0; left_q <= '0; sh_q <= '0;
    end else if (clear_i) begin
      active_q <= 1'b0; keep_q <= 1'b0; dclk_q <= 1'b0; data_q <= 1'b0;
      ph_q <= '0; left_q <= '0; sh_q <= '0;
    end else if (load_i) begin
      active_q <= 1'b1;
      keep_q   <= use_data_i;
      sh_q     <= pat_i;
      left_q   <= nbits_i;
      ph_q     <= '0;
      dclk_q   <= 1'b0;
      if (!use_data_i) data_q <= 1'b0;
    end else if (active_q) begin
      ph_q <= ph_q + 1'b1;
      // clock went low on the previous edge; present the bit one cycle later
      if (ph_q == '0 && keep_q) data_q <= sh_q[0];
      if (ph_q == PH_RISE) dclk_q <= 1'b1;
      if (ph_q == PH_LAST) begin
        dclk_q <= 1'b0;
        ph_q   <= '0;
        sh_q   <= {1'b0, sh_q[7:1]};
        left_q <= left_q - 1'b1;
        if (left_q == NB_W'(1)) active_q <= 1'b0;
      end
    end
  end

  assign dclk_o  = dclk_q;
  assign data0_o = data_q;
  assign busy_o  = active_q;
  assign done_o  = active_q && (ph_q == PH_LAST) && (left_q == NB_W'(1));

  // R5: data is settled before the rising edge latches it
  a_r5_data_stable_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dclk_o) |-> $stable(data0_o));
  // R5: data never moves in the cycle the clock falls
  a_r5_no_change_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dclk_o) |-> $stable(data0_o));

endmodule

// File: rtl/pscfg_master.sv
module pscfg_master
  import pscfg_pkg::*;
#(
  parameter int unsigned CLK_MHZ    = 250,
  parameter int unsigned PULSE_US   = 2,
  parameter int unsigned RELEASE_US = 2,
  parameter int unsigned TIMEOUT_US = 100000,
  parameter int unsigned DCLK_DIV   = 3,
  parameter int unsigned TRAIL_CLKS = 12,
  parameter int unsigned BYTES_W    = 24
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic [BYTES_W-1:0] nbytes_i,
  input  logic               in_valid_i,
  input  logic [7:0]         in_data_i,
  output logic               in_ready_o,
  output logic               nconfig_o,
  output logic               dclk_o,
  output logic               data0_o,
  input  logic               nstatus_i,
  input  logic               conf_done_i,
  output logic               busy_o,
  output logic               ok_o,
  output logic               err_o,
  output logic [1:0]         err_code_o
);

  localparam int unsigned PULSE_CYC  = us_to_cyc(CLK_MHZ, PULSE_US);
  localparam int unsigned REL_CYC    = us_to_cyc(CLK_MHZ, RELEASE_US);
  localparam int unsigned TOUT_CYC   = us_to_cyc(CLK_MHZ, TIMEOUT_US);
  localparam int unsigned SETTLE_CYC = 3;  // covers the two synchronizer flops
  localparam int unsigned TW   = $clog2(max3(PULSE_CYC, REL_CYC, TOUT_CYC) + 1);
  localparam int unsigned NB_W = $clog2(max2(8, TRAIL_CLKS) + 1);

  // named internal events
  logic             ns_s, cd_s, crc_hit, accept, abort, finish;
  logic             tmr_load, tmr_zero;
  logic [TW-1:0]    tmr_val;
  logic             sh_load, sh_use, sh_busy, sh_done;
  logic [7:0]       sh_pat;
  logic [NB_W-1:0]  sh_nbits;
  logic [1:0]       pins_s;

  state_e           st_q, st_n;
  err_e             code_q, code_n;
  logic [BYTES_W-1:0] left_q;
  logic             ok_q, err_q;

  pscfg_sync #(.W(2), .RST(2'b01)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i({conf_done_i, nstatus_i}), .q_o(pins_s)
  );
  assign ns_s = pins_s[0];
  assign cd_s = pins_s[1];

  pscfg_timer #(.W(TW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load_i(tmr_load), .val_i(tmr_val), .zero_o(tmr_zero)
  );

  pscfg_shifter #(.DIV(DCLK_DIV), .NB_W(NB_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .clear_i(abort), .load_i(sh_load), .pat_i(sh_pat),
    .nbits_i(sh_nbits), .use_data_i(sh_use), .dclk_o(dclk_o), .data0_o(data0_o),
    .busy_o(sh_busy), .done_o(sh_done)
  );

  assign crc_hit    = !ns_s && !cd_s;
  assign in_ready_o = (st_q == S_LOAD) && !sh_busy && (left_q != '0) && !crc_hit;
  assign accept     = in_valid_i && in_ready_o;

  always_comb begin
    st_n = st_q; code_n = code_q; abort = 1'b0; finish = 1'b0;
    tmr_load = 1'b0; tmr_val = '0;
    sh_load = 1'b0; sh_pat = in_data_i; sh_nbits = NB_W'(8); sh_use = 1'b1;
    unique case (st_q)
      S_IDLE: if (start_i) begin
        st_n = S_PULSE; tmr_load = 1'b1; tmr_val = TW'(PULSE_CYC);
      end
      S_PULSE: if (tmr_zero) begin
        if (ns_s) begin abort = 1'b1; code_n = ERR_NOSTATUS; end
        else begin st_n = S_RELWAIT; tmr_load = 1'b1; tmr_val = TW'(REL_CYC); end
      end
      S_RELWAIT: if (tmr_zero) begin
        st_n = S_POLL; tmr_load = 1'b1; tmr_val = TW'(TOUT_CYC);
      end
      S_POLL: begin
        if (ns_s) st_n = S_LOAD;
        else if (tmr_zero) begin abort = 1'b1; code_n = ERR_TIMEOUT; end
      end
      S_LOAD: begin
        if (crc_hit) begin abort = 1'b1; code_n = ERR_CRC; end
        else if (accept) sh_load = 1'b1;
        else if (left_q == '0 && !sh_busy) begin
          st_n = S_CHECK; tmr_load = 1'b1; tmr_val = TW'(SETTLE_CYC);
        end
      end
      S_CHECK: if (tmr_zero) begin
        if (cd_s) begin
          st_n = S_TRAIL; sh_load = 1'b1; sh_use = 1'b0;
          sh_pat = '0; sh_nbits = NB_W'(TRAIL_CLKS);
        end else begin abort = 1'b1; code_n = ERR_NODONE; end
      end
      S_TRAIL: if (sh_done) begin st_n = S_IDLE; finish = 1'b1; end
      default: st_n = S_IDLE;
    endcase
    if (abort) st_n = S_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S_IDLE; left_q <= '0; ok_q <= 1'b0; err_q <= 1'b0; code_q <= ERR_NOSTATUS;
    end else begin
      st_q <= st_n;
      if (st_q == S_IDLE && start_i) begin
        left_q <= nbytes_i; ok_q <= 1'b0; err_q <= 1'b0;
      end
      if (accept) left_q <= left_q - 1'b1;
      if (abort) begin err_q <= 1'b1; code_q <= code_n; end
      if (finish) ok_q <= 1'b1;
    end
  end

  assign nconfig_o  = (st_q != S_PULSE);
  assign busy_o     = (st_q != S_IDLE);
  assign ok_o       = ok_q;
  assign err_o      = err_q;
  assign err_code_o = code_q;

  // R1: the request pulse lasts more than a single cycle
  a_r1_pulse_held: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(nconfig_o) |=> !nconfig_o);
  // R2: no serial clock before the device has released its status line
  a_r2_quiet_before_load: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q inside {S_PULSE, S_RELWAIT, S_POLL}) |-> !dclk_o);
  // R9: success and failure never reported together
  a_r9_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(ok_o && err_o));
  // R11: pins are idle in the cycle the error appears
  a_r11_abort_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_o) |-> (nconfig_o && !dclk_o && !data0_o && !busy_o));
  // R12: a byte is only taken while the serializer is quiet
  a_r12_ready_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready_o |-> (!dclk_o && busy_o && nconfig_o));

endmodule

// File: tb/pscfg_master_tb.sv
module pscfg_master_tb;

  localparam int unsigned MHZ = 250, PUS = 2, RUS = 2, TUS = 20, DIV = 3, TRAIL = 12;
  localparam int PULSE_CYC = MHZ * PUS;
  localparam int TOUT_CYC  = MHZ * TUS;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;  // 250 MHz

  logic start = 1'b0, in_valid = 1'b0;
  logic [23:0] nbytes = '0;
  logic [7:0]  in_data = '0;
  logic in_ready_o, nconfig_o, dclk_o, data0_o, busy_o, ok_o, err_o;
  logic [1:0] err_code_o;
  logic nstatus_i, conf_done_i;

  // device model: 0 normal, 1 status never low, 2 status stuck low, 3 checksum error, 4 never done
  int mode = 0, exp_bits = 8, crc_at = 10;
  int bitcnt = 0;
  assign nstatus_i   = (mode == 1) ? 1'b1 : (mode == 2) ? 1'b0 :
                       (mode == 3 && bitcnt >= crc_at) ? 1'b0 : nconfig_o;
  assign conf_done_i = (mode == 3 || mode == 4) ? 1'b0 : (bitcnt >= exp_bits);

  pscfg_master #(.CLK_MHZ(MHZ), .PULSE_US(PUS), .RELEASE_US(RUS), .TIMEOUT_US(TUS),
                 .DCLK_DIV(DIV), .TRAIL_CLKS(TRAIL), .BYTES_W(24)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .nbytes_i(nbytes), .in_valid_i(in_valid),
    .in_data_i(in_data), .in_ready_o(in_ready_o), .nconfig_o(nconfig_o), .dclk_o(dclk_o),
    .data0_o(data0_o), .nstatus_i(nstatus_i), .conf_done_i(conf_done_i), .busy_o(busy_o),
    .ok_o(ok_o), .err_o(err_o), .err_code_o(err_code_o)
  );

  // scoreboard and pin monitor, sampled on the falling edge
  bit exp_q[$];
  int run_id = 0, seen_id = 0;
  int cyc = 0, trail_cnt = 0, mon_bad = 0, nfall = 0, min_hi = 1000, min_lo = 1000;
  int dviol = 0, rdy_viol = 0, lo_len = 0, pulse_len = 0, t_rel = 0, t_err = 0;
  int t_rise = 0, t_fall = 0;
  bit had_fall = 0;
  logic p_dclk = 1'b0, p_data = 1'b0, p_ncfg = 1'b1, p_err = 1'b0;

  always @(negedge clk) begin
    cyc++;
    if (run_id != seen_id) begin
      seen_id = run_id; exp_q.delete(); bitcnt = 0; trail_cnt = 0; mon_bad = 0; nfall = 0;
      min_hi = 1000; min_lo = 1000; dviol = 0; rdy_viol = 0; had_fall = 0; pulse_len = 0;
    end
    if (dclk_o && !p_dclk) begin
      if (had_fall && (cyc - t_fall) < min_lo) min_lo = cyc - t_fall;
      t_rise = cyc;
      if (exp_q.size() > 0) begin
        bit e;
        e = exp_q.pop_front();
        if (data0_o !== e) begin
          mon_bad++;
          $display("R4 bit mismatch at bit %0d: got %0b want %0b", bitcnt, data0_o, e);
        end
      end else trail_cnt++;
      bitcnt++;
    end
    if (!dclk_o && p_dclk) begin
      if ((cyc - t_rise) < min_hi) min_hi = cyc - t_rise;
      t_fall = cyc; had_fall = 1;
    end
    if (data0_o != p_data && (dclk_o || p_dclk)) dviol++;
    if (in_ready_o && !busy_o) rdy_viol++;
    if (!nconfig_o && p_ncfg) begin nfall++; lo_len = 0; end
    if (!nconfig_o) lo_len++;
    if (nconfig_o && !p_ncfg) begin pulse_len = lo_len; t_rel = cyc; end
    if (err_o && !p_err) t_err = cyc;
    p_dclk = dclk_o; p_data = data0_o; p_ncfg = nconfig_o; p_err = err_o;
  end

  int nchk = 0, nbad = 0;
  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic idle_pins(input string tag);
    chk(nconfig_o && !dclk_o && !data0_o && !busy_o, tag,
        {nconfig_o, dclk_o, data0_o, busy_o}, 4'b1000);
  endtask

  logic [7:0] pay [4] = '{8'hA5, 8'h3C, 8'h80, 8'h01};
  int accepted = 0;

  task automatic send_byte(input logic [7:0] b, output bit got);
    in_data = b; in_valid = 1'b1; got = 0;
    while (1) begin
      @(negedge clk);
      if (in_ready_o) begin got = 1; break; end
      if (!busy_o) break;
    end
    if (got) for (int k = 0; k < 8; k++) exp_q.push_back(b[k]);  // bit 0 first
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic run_load(input int m, input int n, input int first, input bit poke,
                          input bit extra);
    bit got;
    mode = m; exp_bits = n * 8; run_id++;
    repeat (2) @(negedge clk);
    nbytes = 24'(n); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy_o && !err_o && !ok_o, "R9 start clears flags", {busy_o, err_o, ok_o}, 3'b100);
    accepted = 0;
    for (int i = 0; i < n + int'(extra); i++) begin
      send_byte(pay[(first + i) % 4], got);
      if (got) accepted++;
      if (poke && i == 0) begin
        nbytes = 24'd1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
      end
    end
    while (busy_o) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  bit timed_out = 0;

  initial begin
    fork
      begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state
        idle_pins("R1 idle pins after reset");
        chk(!in_ready_o && !ok_o && !err_o, "R12 no ready/flags after reset",
            {in_ready_o, ok_o, err_o}, 0);

        // normal three-byte load, extra byte offered, start poked while busy
        run_load(0, 3, 0, 1, 1);
        chk(ok_o && !err_o, "R7 success flag", {ok_o, err_o}, 2'b10);
        chk(mon_bad == 0 && exp_q.size() == 0, "R4 serial stream LSB first", mon_bad, 0);
        chk(trail_cnt == TRAIL, "R7 trailing clock count", trail_cnt, TRAIL);
        chk(pulse_len >= PULSE_CYC, "R1 request pulse length", pulse_len, PULSE_CYC);
        chk(min_hi >= DIV && min_lo >= DIV, "R5 clock phase width", min_hi < min_lo ? min_hi : min_lo, DIV);
        chk(dviol == 0, "R5 data changes only while clock low", dviol, 0);
        chk(nfall == 1, "R10 start while busy ignored", nfall, 1);
        chk(accepted == 3, "R12 exact byte count accepted", accepted, 3);
        chk(rdy_viol == 0, "R12 ready only while busy", rdy_viol, 0);
        idle_pins("R1 idle pins after success");

        // single byte 0x01
        run_load(0, 1, 3, 0, 0);
        chk(ok_o && mon_bad == 0 && trail_cnt == TRAIL, "R4 single byte load",
            trail_cnt, TRAIL);

        // status never asserted
        run_load(1, 2, 0, 0, 0);
        chk(err_o && err_code_o == 2'd0, "R2 no status error code", err_code_o, 0);
        chk(bitcnt == 0, "R2 no clock pulses", bitcnt, 0);
        idle_pins("R11 idle pins after abort");
        repeat (40) @(negedge clk);
        chk(err_o && err_code_o == 2'd0 && !ok_o, "R9 error held", err_code_o, 0);

        // status stuck low
        run_load(2, 2, 0, 0, 0);
        chk(err_o && err_code_o == 2'd1, "R3 timeout error code", err_code_o, 1);
        chk(t_err - t_rel >= TOUT_CYC, "R3 timeout not early", t_err - t_rel, TOUT_CYC);
        chk(bitcnt == 0, "R3 no clock pulses", bitcnt, 0);

        // checksum error after ten bits
        crc_at = 10;
        run_load(3, 3, 1, 0, 0);
        chk(err_o && err_code_o == 2'd2, "R8 checksum error code", err_code_o, 2);
        chk(mon_bad == 0, "R4 bits before checksum error", mon_bad, 0);
        idle_pins("R11 idle pins after checksum abort");

        // done never rises
        run_load(4, 2, 2, 0, 0);
        chk(err_o && err_code_o == 2'd3 && !ok_o, "R6 not-done error code", err_code_o, 3);
        chk(trail_cnt == 0, "R6 no trailing clocks", trail_cnt, 0);
        chk(accepted == 2 && mon_bad == 0, "R12 all bytes sent before check", accepted, 2);
      end
      begin
        repeat (200000) @(posedge clk);
        timed_out = 1;
      end
    join_any
    disable fork;
    if (timed_out) chk(0, "watchdog expired", 0, 1);
    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end

endmodule